// File: doc/BRIEF.md
# Soft-Ramped Stereo Volume Attenuator

This block scales a stereo stream of 20-bit two's-complement samples by one shared digital gain. Samples arrive in parallel with a one-cycle valid strobe, and the scaled left and right results leave one clock later with their own valid flag. The gain is a fraction whose denominator is 1024: a gain of 0 gives silence and a gain of 1024 passes the sample unchanged.

A three-wire serial control port carries an 11-bit gain target. The port has a data line, a bit clock and a latch pulse, all sampled and synchronised by the block clock. The applied gain never jumps. A working gain register moves toward the target by a fixed amount on each accepted sample. A new target written in the middle of a ramp turns the ramp at once.

A mute input drives the ramp toward zero over at most 512 samples. Releasing mute brings the gain back to the latched target at the same rate. Targets written while mute is active are stored and take effect when mute is released.

Top module: `ramp_volume`

## Requirements
- R1: A control word is 11 bits, shifted in MSB first, one bit on each rising edge of `ser_clk_i`. A rising edge of `ser_le_i` copies the last 11 bits shifted into the gain target.
- R2: A latched control word above 1024 sets the target to 1024.
- R3: While `rst_ni` is low, `out_left_o`, `out_right_o` and `out_valid_o` are 0. Reset sets both the target and the working gain to 1024 (unity).
- R4: For each cycle with `smp_valid_i` high, the next cycle has `out_valid_o` high. Each output equals floor(sample × g / 1024), saturated to the signed 20-bit range, where g is the working gain held before that strobe. In every other cycle `out_valid_o` is low.
- R5: On each valid sample the working gain moves 2 units toward the goal. If the goal is 2 units away or less, the gain lands on it exactly, with no overshoot.
- R6: A target latched in the middle of a ramp turns the ramp toward the new target on the next sample.
- R7: While `mute_i` is high the goal is 0, so a gain of 1024 reaches 0 after 512 samples and then stays there. After `mute_i` falls, the gain ramps back to the latched target at 2 units per sample.
- R8: A control word latched while `mute_i` is high changes the target only. The output stays silent until mute is released, and the gain then ramps to the new target.
- R9: Cycles without `smp_valid_i` leave the working gain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_dat_i | input | 1 | Serial control data, MSB first |
| ser_clk_i | input | 1 | Serial control bit clock, shifts on its rising edge |
| ser_le_i | input | 1 | Latch pulse, its rising edge loads the target |
| mute_i | input | 1 | Ramp to silence while high |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample pair |
| smp_left_i | input | 20 | Left sample, two's complement |
| smp_right_i | input | 20 | Right sample, two's complement |
| out_valid_o | output | 1 | Scaled sample pair is valid |
| out_left_o | output | 20 | Scaled left sample |
| out_right_o | output | 20 | Scaled right sample |

## Verification
The bench builds the block with its default parameters: 20-bit samples, an 11-bit gain at unity 1024, a step of 2 and two synchroniser stages. With these values a full mute ramp lasts 512 samples and a full-scale ramp takes a few hundred, so complete ramps, odd targets that land off the step grid, and turns in the middle of a ramp all fit in a short run. Feeding a sample of 1024 makes the output equal the working gain, which exposes each ramp step at the ports. Samples at the extremes of the 20-bit range exercise the floor rounding of negative products.

// File: rtl/ramp_volume_pkg.sv
package ramp_volume_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/serial_gain_port.sv
module serial_gain_port #(
  parameter int GAIN_W = 11,
  parameter int UNITY  = 1024,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_dat_i,
  input  logic              ser_clk_i,
  input  logic              ser_le_i,
  output logic [GAIN_W-1:0] target_o
);
  localparam logic [GAIN_W-1:0] UNITY_V = GAIN_W'(UNITY);

  logic [SYNC-1:0]   clk_s, le_s, dat_s;
  logic              clk_d, le_d;
  logic [GAIN_W-1:0] shreg;
  logic              clk_rise, le_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_s <= '0;
      le_s  <= '0;
      dat_s <= '0;
      clk_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      clk_s <= {clk_s[SYNC-2:0], ser_clk_i};
      le_s  <= {le_s[SYNC-2:0], ser_le_i};
      dat_s <= {dat_s[SYNC-2:0], ser_dat_i};
      clk_d <= clk_s[SYNC-1];
      le_d  <= le_s[SYNC-1];
    end
  end

  assign clk_rise = clk_s[SYNC-1] & ~clk_d;
  assign le_rise  = le_s[SYNC-1] & ~le_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg    <= '0;
      target_o <= UNITY_V;
    end else begin
      if (clk_rise) shreg <= {shreg[GAIN_W-2:0], dat_s[SYNC-1]};
      if (le_rise)  target_o <= (shreg > UNITY_V) ? UNITY_V : shreg;
    end
  end
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp
  import ramp_volume_pkg::*;
#(
  parameter int GAIN_W = 11,
  parameter int UNITY  = 1024,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] STEP_V  = GAIN_W'(STEP);
  localparam logic [GAIN_W-1:0] UNITY_V = GAIN_W'(UNITY);

  logic [GAIN_W-1:0] goal, gain_nxt;
  ramp_dir_e         dir;

  assign goal = mute_i ? '0 : target_i;

  always_comb begin
    if (gain_o < goal)      dir = RAMP_UP;
    else if (gain_o > goal) dir = RAMP_DOWN;
    else                    dir = RAMP_HOLD;
  end

  always_comb begin
    case (dir)
      RAMP_UP:   gain_nxt = (goal - gain_o <= STEP_V) ? goal : gain_o + STEP_V;
      RAMP_DOWN: gain_nxt = (gain_o - goal <= STEP_V) ? goal : gain_o - STEP_V;
      default:   gain_nxt = gain_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gain_o <= UNITY_V;
    else if (step_i) gain_o <= gain_nxt;
  end
endmodule

// File: rtl/channel_scaler.sv
module channel_scaler #(
  parameter int DATA_W = 20,
  parameter int GAIN_W = 11,
  parameter int FRAC   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0]     prod, shf;
  logic        [DATA_W-1:0] sat;

  always_comb begin
    prod = $signed(smp_i) * $signed({1'b0, gain_i});
    shf  = prod >>> FRAC;
    if (shf > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (shf < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_o <= '0;
    else if (en_i) res_o <= sat;
  end
endmodule

// File: rtl/ramp_volume.sv
module ramp_volume #(
  parameter int DATA_W = 20,
  parameter int GAIN_W = 11,
  parameter int FRAC   = 10,
  parameter int STEP   = 2,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_dat_i,
  input  logic              ser_clk_i,
  input  logic              ser_le_i,
  input  logic              mute_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o
);
  localparam int UNITY = 1 << FRAC;
  localparam int NCH   = 2;

  logic [GAIN_W-1:0]           target_gain, cur_gain;
  logic [NCH-1:0][DATA_W-1:0]  smp_in, smp_out;

  serial_gain_port #(.GAIN_W(GAIN_W), .UNITY(UNITY), .SYNC(SYNC)) u_port (
    .clk_i, .rst_ni, .ser_dat_i, .ser_clk_i, .ser_le_i, .target_o(target_gain)
  );

  gain_ramp #(.GAIN_W(GAIN_W), .UNITY(UNITY), .STEP(STEP)) u_ramp (
    .clk_i, .rst_ni, .step_i(smp_valid_i), .mute_i,
    .target_i(target_gain), .gain_o(cur_gain)
  );

  assign smp_in[0] = smp_left_i;
  assign smp_in[1] = smp_right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    channel_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_scl (
      .clk_i, .rst_ni, .en_i(smp_valid_i), .smp_i(smp_in[c]),
      .gain_i(cur_gain), .res_o(smp_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= smp_valid_i;
  end

  assign out_left_o  = smp_out[0];
  assign out_right_o = smp_out[1];
endmodule

// File: rtl/ramp_volume_chk.sv
module ramp_volume_chk #(
  parameter int DATA_W = 20,
  parameter int GAIN_W = 11,
  parameter int UNITY  = 1024,
  parameter int STEP   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mute_i,
  input logic              smp_valid_i,
  input logic [DATA_W-1:0] smp_left_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_left_o,
  input logic [DATA_W-1:0] out_right_o,
  input logic [GAIN_W-1:0] gain_q,
  input logic [GAIN_W-1:0] target_q
);
  assert_reset_quiet_R3: assert property (@(posedge clk_i)
    !rst_ni |-> (out_left_o == '0 && out_right_o == '0 && !out_valid_o));

  assert_valid_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o);

  assert_valid_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !out_valid_o);

  assert_zero_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_left_i == '0) |=> out_left_o == '0);

  assert_target_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_q <= GAIN_W'(UNITY));

  assert_gain_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> ((gain_q >= $past(gain_q)) ? (gain_q - $past(gain_q))
                                               : ($past(gain_q) - gain_q)) <= GAIN_W'(STEP));

  assert_mute_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i && smp_valid_i && gain_q == '0) |=> gain_q == '0);

  assert_gain_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(gain_q));
endmodule

bind ramp_volume ramp_volume_chk #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .UNITY(UNITY), .STEP(STEP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mute_i(mute_i), .smp_valid_i(smp_valid_i),
  .smp_left_i(smp_left_i), .out_valid_o(out_valid_o), .out_left_o(out_left_o),
  .out_right_o(out_right_o), .gain_q(cur_gain), .target_q(target_gain)
);

// File: tb/sim_ramp_volume.sv
module sim_ramp_volume;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        sdat = 1'b0, sclk = 1'b0, sle = 1'b0, mute = 1'b0, vld = 1'b0;
  logic [19:0] in_l = '0, in_r = '0;
  logic        o_vld;
  logic [19:0] o_l, o_r;

  int checks = 0, errors = 0;
  int gain_m = 1024, tgt_m = 1024;
  bit done = 0;

  always #2 clk = ~clk;

  ramp_volume u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_dat_i(sdat), .ser_clk_i(sclk), .ser_le_i(sle),
    .mute_i(mute), .smp_valid_i(vld), .smp_left_i(in_l), .smp_right_i(in_r),
    .out_valid_o(o_vld), .out_left_o(o_l), .out_right_o(o_r)
  );

  function automatic int scale(int s, int g);
    longint p;
    p = longint'(s) * longint'(g);
    p = p >>> 10;
    if (p > 524287) p = 524287;
    if (p < -524288) p = -524288;
    return int'(p);
  endfunction

  function automatic int step_gain(int g, int goal);
    if (g < goal) return (goal - g <= 2) ? goal : g + 2;
    if (g > goal) return (g - goal <= 2) ? goal : g - 2;
    return g;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one sample pair, check outputs one cycle later
  task automatic sample(string tag, int l, int r);
    @(negedge clk);
    in_l = 20'(l); in_r = 20'(r); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check({tag, " valid"}, int'(o_vld), 1);
    check({tag, " left"}, int'($signed(o_l)), scale(l, gain_m));
    check({tag, " right"}, int'($signed(o_r)), scale(r, gain_m));
    gain_m = step_gain(gain_m, mute ? 0 : tgt_m);
  endtask

  task automatic probe(string tag, int n);
    for (int i = 0; i < n; i++) sample(tag, 1024, -1024);
  endtask

  task automatic write_word(int v);
    for (int b = 10; b >= 0; b--) begin
      @(negedge clk); sdat = 1'((v >> b) & 1); sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0; sle = 1'b1;
    repeat (4) @(negedge clk);
    sle = 1'b0;
    repeat (4) @(negedge clk);
    tgt_m = (v > 1024) ? 1024 : v;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 valid in reset", int'(o_vld), 0);
    check("R3 left in reset", int'(o_l), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 valid idle", int'(o_vld), 0);

    // unity after reset, full-scale and negative rounding
    probe("R3 unity", 1);
    sample("R4 max", 524287, -524288);
    sample("R4 small neg", -3, 7);

    write_word(512);                 // R1
    probe("R5 down to 512", 260);
    check("R1 R5 settled", gain_m, 512);
    probe("R5 hold", 1);

    write_word(1500);                // R2 clamp
    probe("R2 clamp ramp", 260);
    check("R2 clamped gain", gain_m, 1024);

    write_word(5);
    sample("R4 after target", -524288, 524287);
    probe("R5 odd target", 515);
    check("R5 exact landing", gain_m, 5);

    write_word(1000);
    probe("R6 rising", 20);
    write_word(10);                  // R6 turn mid-ramp
    probe("R6 turned", 30);
    check("R6 final", gain_m, 10);

    repeat (60) @(negedge clk);      // R9 idle, no samples
    probe("R9 unchanged", 1);

    write_word(11'h400);
    probe("R1 unity", 520);
    mute = 1'b1;                     // R7 full mute span
    probe("R7 ramp", 511);
    check("R7 one step left", gain_m, 2);
    probe("R7 reached", 1);
    check("R7 zero at 512", gain_m, 0);
    write_word(300);                 // R8 write while muted
    probe("R8 still silent", 20);
    mute = 1'b0;
    probe("R8 release", 160);
    check("R8 new target", gain_m, 300);

    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) write_word($urandom_range(0, 2047));
      else if (r < 6) mute = ~mute;
      else if (r < 8) repeat ($urandom_range(1, 10)) @(negedge clk);
      sample("R4 R5 random", int'($signed(20'($urandom))), int'($signed(20'($urandom))));
    end
    mute = 1'b0;

    write_word(100);
    probe("R3 pre-reset", 10);
    @(negedge clk); in_l = 20'd1000; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R3 reset forces zero", int'(o_l), 0);
    rst_n = 1'b1;
    gain_m = 1024; tgt_m = 1024;
    repeat (2) @(negedge clk);
    probe("R3 target unity after reset", 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule